// File: doc/BRIEF.md
# PWM Trap Shutdown Guard

This block sits between a PWM generator and the output pins. When an active-low emergency input is pulled low, it drives selected PWM outputs to programmed safe levels. The emergency input only acts while its enable is set. The block has six channel outputs and one auxiliary output, which belongs to the second timer.

A trip sets a sticky flag and enters the trap state. The pin is brought into the clock domain through a short synchronizer. Software chooses when the trap state may end. It can end as soon as the pin is released, or only on a period-boundary pulse from timer A or from timer B. It can also be made to wait until software has cleared the flag after the release.

All pins of this block are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure to honour. The output vectors are combinational from the registered trap state and the current raw inputs.

Top module: `pwm_trap_guard`

## Requirements
- R1: After reset, the trap flag and the trap state are 0, and every output equals its raw input.
- R2: The emergency pin is active low. While the pin enable is 0, a low pin changes neither the flag nor the state, and all outputs pass through.
- R3: When the enabled pin is low at a clock edge, the flag and the state read 1 after the third clock edge that samples it low (two synchronizer stages plus the state register). From then on the outputs are forced, whatever exit mode is selected.
- R4: The flag is sticky. It stays 1 until a clear strobe arrives while the synchronized pin is inactive. A clear strobe that arrives while the pin is still active has no effect.
- R5: With exit mode 2'b00 or 2'b11, the state returns to 0 at the first edge at which the synchronized pin is inactive and the release condition of R7 holds.
- R6: With exit mode 2'b01, the state can only return to 0 at an edge where the timer A boundary pulse is 1. With mode 2'b10, the same holds for the timer B pulse. The pulse of the timer that is not selected has no effect.
- R7: When need-clear is 1, the state stays 1 while the flag is 1. It can leave at the edge after the edge that cleared the flag.
- R8: If the pin becomes active again while an exit is pending, the pending exit is cancelled. The state stays 1, and the flag is set again.
- R9: Channel output i equals passive level i while the state is 1 and trap enable i is 1. Otherwise it equals raw input i.
- R10: The auxiliary output equals its passive-level bit while the state is 1 and its own trap enable is 1. Otherwise it equals its raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_pin_n_i | input | 1 | Emergency input, active low, asynchronous |
| pin_en_i | input | 1 | Enables tripping from the pin |
| exit_mode_i | input | 2 | 00/11 free exit, 01 timer A boundary, 10 timer B boundary |
| need_clear_i | input | 1 | Exit also waits for the flag to be cleared |
| tmr_a_period_i | input | 1 | Period-boundary pulse, timer A |
| tmr_b_period_i | input | 1 | Period-boundary pulse, timer B |
| flag_clr_i | input | 1 | Flag clear strobe |
| pwm_i | input | NUM_CH | Raw channel outputs |
| trap_en_i | input | NUM_CH | Per-channel trap enable |
| passive_lvl_i | input | NUM_CH | Per-channel passive level |
| aux_pwm_i | input | 1 | Raw auxiliary output |
| aux_trap_en_i | input | 1 | Auxiliary trap enable |
| aux_passive_i | input | 1 | Auxiliary passive level |
| pwm_o | output | NUM_CH | Gated channel outputs |
| aux_pwm_o | output | 1 | Gated auxiliary output |
| trap_flag_o | output | 1 | Sticky trap flag |
| trap_state_o | output | 1 | Trap state active |

## Verification
The bench builds the block with NUM_CH = 6 and SYNC_STAGES = 2. With these values its queue-based delay model lines up edge for edge with the stated three-edge trip latency. Six channels are enough to use mixed enable and passive-level masks, so forced and pass-through bits appear side by side while the raw pattern changes every cycle. Running every exit mode with and without need-clear brings these cases within reach: a pulse from the wrong timer, a clear strobe that arrives too early, and a trip that returns while an exit is pending.

// File: rtl/pwm_trap_pkg.sv
package pwm_trap_pkg;
  typedef enum logic [1:0] {
    EXIT_FREE     = 2'b00,
    EXIT_TMR_A    = 2'b01,
    EXIT_TMR_B    = 2'b10,
    EXIT_FREE_ALT = 2'b11
  } exit_sync_e;
endpackage

// File: rtl/trap_pin_sync.sv
module trap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic pin_n_sync_o
);
  logic [STAGES-1:0] shift_q;

  // Reset to the inactive (high) level so that no trip is seen out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= {shift_q[STAGES-2:0], pin_n_i};
  end

  assign pin_n_sync_o = shift_q[STAGES-1];
endmodule

// File: rtl/trap_state_ctrl.sv
module trap_state_ctrl
  import pwm_trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_i,
  input  exit_sync_e exit_mode_i,
  input  logic       need_clear_i,
  input  logic       tmr_a_i,
  input  logic       tmr_b_i,
  input  logic       flag_clr_i,
  output logic       flag_o,
  output logic       state_o
);
  logic flag_q, state_q;
  logic boundary_ok, release_ok, leave;

  always_comb begin
    unique case (exit_mode_i)
      EXIT_TMR_A: boundary_ok = tmr_a_i;
      EXIT_TMR_B: boundary_ok = tmr_b_i;
      default:    boundary_ok = 1'b1;
    endcase
  end

  // The flag can only be clear once the pin is inactive (a set wins over a clear).
  assign release_ok = !need_clear_i || !flag_q;
  assign leave      = release_ok && boundary_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      state_q <= 1'b0;
    end else begin
      flag_q <= trip_i || (flag_q && !flag_clr_i);
      if (trip_i)     state_q <= 1'b1;
      else if (leave) state_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign state_o = state_q;
endmodule

// File: rtl/trap_out_gate.sv
module trap_out_gate #(
  parameter int WIDTH = 6
) (
  input  logic             force_i,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] out_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign out_o[g] = (force_i && en_i[g]) ? lvl_i[g] : raw_i[g];
  end
endmodule

// File: rtl/pwm_trap_guard.sv
module pwm_trap_guard
  import pwm_trap_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_pin_n_i,
  input  logic              pin_en_i,
  input  logic [1:0]        exit_mode_i,
  input  logic              need_clear_i,
  input  logic              tmr_a_period_i,
  input  logic              tmr_b_period_i,
  input  logic              flag_clr_i,
  input  logic [NUM_CH-1:0] pwm_i,
  input  logic [NUM_CH-1:0] trap_en_i,
  input  logic [NUM_CH-1:0] passive_lvl_i,
  input  logic              aux_pwm_i,
  input  logic              aux_trap_en_i,
  input  logic              aux_passive_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              aux_pwm_o,
  output logic              trap_flag_o,
  output logic              trap_state_o
);
  logic pin_n_sync;
  logic trip;
  logic state;

  trap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_n_i      (trap_pin_n_i),
    .pin_n_sync_o (pin_n_sync)
  );

  assign trip = pin_en_i && !pin_n_sync;

  trap_state_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_i       (trip),
    .exit_mode_i  (exit_sync_e'(exit_mode_i)),
    .need_clear_i (need_clear_i),
    .tmr_a_i      (tmr_a_period_i),
    .tmr_b_i      (tmr_b_period_i),
    .flag_clr_i   (flag_clr_i),
    .flag_o       (trap_flag_o),
    .state_o      (state)
  );

  trap_out_gate #(.WIDTH(NUM_CH)) u_gate_ch (
    .force_i (state),
    .raw_i   (pwm_i),
    .en_i    (trap_en_i),
    .lvl_i   (passive_lvl_i),
    .out_o   (pwm_o)
  );

  trap_out_gate #(.WIDTH(1)) u_gate_aux (
    .force_i (state),
    .raw_i   (aux_pwm_i),
    .en_i    (aux_trap_en_i),
    .lvl_i   (aux_passive_i),
    .out_o   (aux_pwm_o)
  );

  assign trap_state_o = state;
endmodule

// File: rtl/pwm_trap_guard_chk.sv
module pwm_trap_guard_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trip,
  input logic              pin_en_i,
  input logic [1:0]        exit_mode_i,
  input logic              need_clear_i,
  input logic              tmr_a_period_i,
  input logic              tmr_b_period_i,
  input logic              flag_clr_i,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] trap_en_i,
  input logic [NUM_CH-1:0] passive_lvl_i,
  input logic              aux_pwm_i,
  input logic              aux_trap_en_i,
  input logic              aux_passive_i,
  input logic [NUM_CH-1:0] pwm_o,
  input logic              aux_pwm_o,
  input logic              trap_flag_o,
  input logic              trap_state_o
);
  a_r2_pin_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en_i && !trap_flag_o && !trap_state_o) |=> (!trap_flag_o && !trap_state_o));

  a_r3_trip_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (trap_flag_o && trap_state_o));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_flag_o && !flag_clr_i) |=> trap_flag_o);

  a_r5_free_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_state_o && !trip && (exit_mode_i == 2'b00 || exit_mode_i == 2'b11) &&
     (!need_clear_i || !trap_flag_o)) |=> !trap_state_o);

  a_r6_timer_a_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_state_o && exit_mode_i == 2'b01 && !tmr_a_period_i) |=> trap_state_o);

  a_r6_timer_b_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_state_o && exit_mode_i == 2'b10 && !tmr_b_period_i) |=> trap_state_o);

  a_r7_wait_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_state_o && need_clear_i && trap_flag_o) |=> trap_state_o);

  a_r9_channels_forced: assert property (@(posedge clk) disable iff (!rst_n)
    trap_state_o |-> (((pwm_o ^ passive_lvl_i) & trap_en_i) == '0 &&
                      ((pwm_o ^ pwm_i) & ~trap_en_i) == '0));

  a_r9_channels_free: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_state_o |-> (pwm_o == pwm_i));

  a_r10_aux_output: assert property (@(posedge clk) disable iff (!rst_n)
    aux_pwm_o == ((trap_state_o && aux_trap_en_i) ? aux_passive_i : aux_pwm_i));
endmodule

bind pwm_trap_guard pwm_trap_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trip           (trip),
  .pin_en_i       (pin_en_i),
  .exit_mode_i    (exit_mode_i),
  .need_clear_i   (need_clear_i),
  .tmr_a_period_i (tmr_a_period_i),
  .tmr_b_period_i (tmr_b_period_i),
  .flag_clr_i     (flag_clr_i),
  .pwm_i          (pwm_i),
  .trap_en_i      (trap_en_i),
  .passive_lvl_i  (passive_lvl_i),
  .aux_pwm_i      (aux_pwm_i),
  .aux_trap_en_i  (aux_trap_en_i),
  .aux_passive_i  (aux_passive_i),
  .pwm_o          (pwm_o),
  .aux_pwm_o      (aux_pwm_o),
  .trap_flag_o    (trap_flag_o),
  .trap_state_o   (trap_state_o)
);

// File: tb/pwm_trap_guard_test.sv
module pwm_trap_guard_test;
  localparam int NCH = 6;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1, pin_en = 1'b0, need_clr = 1'b0, ta = 1'b0, tb = 1'b0, clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [NCH-1:0] raw = '0, ten = '0, lvl = '0;
  logic araw = 1'b0, aen = 1'b0, alvl = 1'b0;
  logic [NCH-1:0] out;
  logic aout, flag, state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R1";

  // reference model state
  bit pin_hist[$];
  bit m_flag, m_state;

  always #5 clk = ~clk;

  pwm_trap_guard #(.NUM_CH(NCH), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst_n(rst_n), .trap_pin_n_i(pin_n), .pin_en_i(pin_en),
    .exit_mode_i(mode), .need_clear_i(need_clr), .tmr_a_period_i(ta),
    .tmr_b_period_i(tb), .flag_clr_i(clr), .pwm_i(raw), .trap_en_i(ten),
    .passive_lvl_i(lvl), .aux_pwm_i(araw), .aux_trap_en_i(aen),
    .aux_passive_i(alvl), .pwm_o(out), .aux_pwm_o(aout),
    .trap_flag_o(flag), .trap_state_o(state)
  );

  initial begin
    for (int i = 0; i < SYN; i++) pin_hist.push_back(1'b1);
    m_flag = 1'b0;
    m_state = 1'b0;
  end

  // Behavioural model: the pin seen by the control logic is the one sampled SYN edges earlier.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist.delete();
      for (int i = 0; i < SYN; i++) pin_hist.push_back(1'b1);
      m_flag = 1'b0;
      m_state = 1'b0;
    end else begin
      bit seen, tripped, may_go, at_bound;
      seen = pin_hist.pop_front();
      pin_hist.push_back(pin_n);
      tripped = pin_en && !seen;
      may_go = !need_clr || !m_flag;
      at_bound = (mode == 2'b01) ? ta : (mode == 2'b10) ? tb : 1'b1;
      if (tripped) m_state = 1'b1;
      else if (m_state && may_go && at_bound) m_state = 1'b0;
      if (tripped) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
    end
  end

  task automatic check1(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, before the inputs move.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] e_out;
      for (int i = 0; i < NCH; i++) e_out[i] = (m_state && ten[i]) ? lvl[i] : raw[i];
      check1("flag", 32'(flag), 32'(m_flag));
      check1("state", 32'(state), 32'(m_state));
      check1("pwm_o", 32'(out), 32'(e_out));
      check1("aux", 32'(aout), 32'((m_state && aen) ? alvl : araw));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      raw = NCH'($urandom);
      araw = 1'($urandom);
      ta = 1'b0; tb = 1'b0; clr = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1; clr = 1'b1;
    @(negedge clk); #1; clr = 1'b0;
  endtask

  task automatic pulse_tmr(bit which_a);
    @(negedge clk); #1;
    if (which_a) ta = 1'b1; else tb = 1'b1;
    @(negedge clk); #1; ta = 1'b0; tb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, outputs follow raw inputs
    req = "R1"; ten = 6'b101101; lvl = 6'b100110; aen = 1'b1; alvl = 1'b1;
    cyc(4);
    // R2: pin ignored while disabled
    req = "R2"; pin_n = 1'b0; cyc(8); pin_n = 1'b1; cyc(4);
    check1("flag stays clear", 32'(flag), 32'd0);
    // R3 / R9 / R10: trip and forced outputs, free exit mode
    pin_en = 1'b1;
    req = "R3"; pin_n = 1'b0; cyc(3);
    req = "R9"; cyc(4);
    check1("state after trip", 32'(state), 32'd1);
    req = "R10"; aen = 1'b1; alvl = 1'b0; cyc(3); aen = 1'b0; cyc(2); aen = 1'b1;
    // R4: early clear ignored
    req = "R4"; pulse_clr(); cyc(1);
    check1("flag kept during active pin", 32'(flag), 32'd1);
    // R5: free exit
    req = "R5"; pin_n = 1'b1; cyc(5);
    check1("state left", 32'(state), 32'd0);
    req = "R4"; cyc(2); pulse_clr(); cyc(2);
    check1("flag cleared", 32'(flag), 32'd0);
    // R5 with alternate free encoding
    req = "R5"; mode = 2'b11; pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(5); pulse_clr();
    // R6: timer A exit, timer B pulse ignored
    req = "R6"; mode = 2'b01; ten = 6'b011011; lvl = 6'b010001;
    pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(4);
    pulse_tmr(1'b0); cyc(2);
    check1("wrong timer ignored", 32'(state), 32'd1);
    pulse_tmr(1'b1); cyc(2);
    check1("timer A exit", 32'(state), 32'd0);
    pulse_clr();
    // R6: timer B exit
    mode = 2'b10; pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(4);
    pulse_tmr(1'b1); cyc(2);
    check1("timer A ignored in B mode", 32'(state), 32'd1);
    pulse_tmr(1'b0); cyc(2);
    check1("timer B exit", 32'(state), 32'd0);
    pulse_clr();
    // R7: exit waits for the flag clear
    req = "R7"; mode = 2'b00; need_clr = 1'b1;
    pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(6);
    check1("held for clear", 32'(state), 32'd1);
    pulse_clr(); cyc(2);
    check1("released after clear", 32'(state), 32'd0);
    // R7 with timer A sync
    mode = 2'b01; pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(3);
    pulse_tmr(1'b1); cyc(2); pulse_clr(); cyc(2); pulse_tmr(1'b1); cyc(2);
    need_clr = 1'b0;
    // R8: re-trip while exit pending
    req = "R8"; mode = 2'b01;
    pin_n = 1'b0; cyc(5); pin_n = 1'b1; cyc(3); pulse_clr();
    pin_n = 1'b0; cyc(3); pulse_tmr(1'b1); cyc(1);
    check1("pending exit cancelled", 32'(state), 32'd1);
    check1("flag set again", 32'(flag), 32'd1);
    pin_n = 1'b1; cyc(4); pulse_tmr(1'b1); cyc(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=hung expected=finished", req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule